// File: doc/BRIEF.md
# Set-Associative Line Cache with Parallel Tag and Data Lookup

This block keeps track of which line addresses are held in a set-associative cache, and it holds the line contents. Each access uses one line address. The tag store and the data store are read in the same clock cycle. Every command is accepted and completed in a single cycle, and its results appear on the registered outputs one cycle later. The caller drives four command bits (request, read/write, invalidate, replace), a line address and a line of write data. The caller gets back hit and miss flags, line data and, after a replacement, the tag of the line that was evicted.

The data store is a single-port, read-first array. Any access that writes a line also returns the contents the line held before the write. On a replacement, the incoming line goes into an invalid way of the indexed set if one exists. Otherwise it goes into the least recently used way of that set. The evicted data and address come out on the next cycle, so the caller can write them back. The block does not refill lines or select words. Addresses are line addresses and carry no word or byte offset.

Top module: `cpar_cache`

## Requirements
- R1: The command is decoded from {req_i, rw_i, inv_i, repl_i}:
  - 1000 reads.
  - 1100 updates.
  - 1010 reads and invalidates.
  - 1110 writes and invalidates.
  - 0xx1 replaces.
  - 0000 (or any pattern with req_i low and repl_i low) is idle.
- R2: One cycle after any request, exactly one of hit_o and miss_o is high. hit_o is high only when the address is resident.
- R3: One cycle after an idle or replace-only cycle, hit_o and miss_o are both low.
- R4: A read that hits presents the stored line on line_o one cycle later.
- R5: An update that hits stores line_i. One cycle later line_o shows the previous contents (read-first), and later reads return line_i.
- R6: An invalidating request that hits returns the line on line_o (a write-and-invalidate stores line_i first). Later lookups of that address miss. An invalidating request that misses has no effect.
- R7: A replace (req_i low, repl_i high) writes addr_i and line_i into the victim way. The victim is the lowest-numbered invalid way of the set, or the least recently used way if every way is valid. When the victim was valid, line_o and old_addr_o show its data and address one cycle later. A following request for addr_i hits. The caller must not replace an address that is already resident.
- R8: A hit by a non-invalidating request, and a replace, make the way most recently used. An invalidating hit makes the way least recently used.
- R9: A request that misses and does not invalidate leaves contents, validity and use order unchanged.
- R10: After synchronous active-low reset, every way is invalid and hit_o and miss_o are low.
- R11: The set index is the low log2(NUM_LINES/WAYS) bits of addr_i. Sets are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Lookup request |
| rw_i | input | 1 | With req_i: write line_i into the hit line |
| inv_i | input | 1 | With req_i: invalidate the hit line |
| repl_i | input | 1 | With req_i low: replace a line |
| addr_i | input | ADDR_W | Line address |
| line_i | input | LINE_W | Line data to store |
| line_o | output | LINE_W | Line data read, one cycle late |
| hit_o | output | 1 | Previous request hit |
| miss_o | output | 1 | Previous request missed |
| old_addr_o | output | ADDR_W | Address of line evicted by the previous replace |

## Verification
Directed sequences first fill one set completely. Reads then reorder its use history, so the eviction victim differs from the fill order and the test can tell LRU choice from round-robin or index-based choice. Further sequences distinguish read-first output from write-through output on updates. They also compare invalidation on a hit against invalidation on a miss, and check that a fill of one set leaves the other sets untouched. A seeded random mix of all command kinds, drawn over a small address pool so that hits, misses and evictions are all frequent, is compared cycle by cycle with a behavioural model of sets, ways and use ranks.

// File: rtl/cpar_pkg.sv
// Package: shared command type and decoder for the parallel-lookup cache.
// Assumes: command bits are sampled together on the same clock edge.
package cpar_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_UPDATE,
        OP_READ_DROP,
        OP_WRITE_DROP,
        OP_REPLACE
    } cpar_op_e;

    // Map the four command bits onto one operation; request wins over replace.
    function automatic cpar_op_e cpar_decode(input logic req, input logic rw,
                                             input logic inv, input logic rep);
        if (req) begin
            case ({rw, inv})
                2'b00:   return OP_READ;
                2'b10:   return OP_UPDATE;
                2'b01:   return OP_READ_DROP;
                default: return OP_WRITE_DROP;
            endcase
        end
        else if (rep) begin
            return OP_REPLACE;
        end
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/cpar_tag_unit.sv
// Tag unit: per-set valid bits and full line-address tags. Compares all ways
// of the indexed set in parallel, and picks the hit way and the victim way.
// Assumes: at most one way per set holds a given address (the caller never
// replaces a resident address); lru_way_i refers to the same set.
module cpar_tag_unit #(
    parameter int SETS   = 1,
    parameter int WAYS   = 32,
    parameter int ADDR_W = 8,
    parameter int SET_W  = 1,
    parameter int WAY_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_idx_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_en_i,
    input  logic              fill_en_i,
    input  logic [WAY_W-1:0]  wr_way_i,
    input  logic [WAY_W-1:0]  lru_way_i,
    output logic              hit_o,
    output logic [WAY_W-1:0]  hit_way_o,
    output logic [WAY_W-1:0]  victim_way_o,
    output logic [ADDR_W-1:0] victim_tag_o
);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [ADDR_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   match;
    logic              have_free;
    logic [WAY_W-1:0]  free_way;

    // Compare every way of the set against the address at once.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match[w] = valid_q[set_idx_i][w] && (tag_q[set_idx_i][w] == addr_i);
        end
    end

    // Lowest-numbered matching way and lowest-numbered free way.
    always_comb begin
        hit_way_o = '0;
        free_way  = '0;
        have_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way_o = WAY_W'(w);
            if (!valid_q[set_idx_i][w]) begin
                free_way  = WAY_W'(w);
                have_free = 1'b1;
            end
        end
    end

    assign hit_o        = |match;
    assign victim_way_o = have_free ? free_way : lru_way_i;
    assign victim_tag_o = tag_q[set_idx_i][victim_way_o];

    // Valid bits: cleared on reset and by invalidation, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end
        else if (fill_en_i) begin
            valid_q[set_idx_i][wr_way_i] <= 1'b1;
        end
        else if (clr_en_i) begin
            valid_q[set_idx_i][wr_way_i] <= 1'b0;
        end
    end

    // Tag storage: written only by a fill, needs no reset.
    always_ff @(posedge clk) begin
        if (fill_en_i) tag_q[set_idx_i][wr_way_i] <= addr_i;
    end

endmodule

// File: rtl/cpar_lru.sv
// Use-order tracker: each way of each set holds a rank, 0 = most recently
// used, WAYS-1 = least recently used. The ranks of a set are always a
// permutation. Promote moves a way to rank 0, demote moves it to WAYS-1.
// Assumes: promote and demote are never both high.
module cpar_lru #(
    parameter int SETS  = 1,
    parameter int WAYS  = 32,
    parameter int SET_W = 1,
    parameter int WAY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx_i,
    input  logic             promote_i,
    input  logic             demote_i,
    input  logic [WAY_W-1:0] way_i,
    output logic [WAY_W-1:0] lru_way_o
);

    localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic [WAY_W-1:0] own_rank;

    assign own_rank = rank_q[set_idx_i][way_i];

    // Find the way holding the last rank in the indexed set.
    always_comb begin
        lru_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_q[set_idx_i][w] == LAST) lru_way_o = WAY_W'(w);
        end
    end

    // Reset to rank = way number, then shift ranks around the touched way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end
        else if (promote_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == way_i)
                    rank_q[set_idx_i][w] <= '0;
                else if (rank_q[set_idx_i][w] < own_rank)
                    rank_q[set_idx_i][w] <= rank_q[set_idx_i][w] + 1'b1;
            end
        end
        else if (demote_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == way_i)
                    rank_q[set_idx_i][w] <= LAST;
                else if (rank_q[set_idx_i][w] > own_rank)
                    rank_q[set_idx_i][w] <= rank_q[set_idx_i][w] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpar_data_mem.sv
// Line storage: single-port, read-first. On an enabled access the old word
// at the address is registered onto rdata_o even when the access writes.
// Assumes: contents are undefined until written; rdata_o holds when idle.
module cpar_data_mem #(
    parameter int DEPTH  = 32,
    parameter int LINE_W = 8,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [LINE_W-1:0] wdata_i,
    output logic [LINE_W-1:0] rdata_o
);

    logic [LINE_W-1:0] mem_q [DEPTH];

    // Read the old word, then write the new one in the same edge.
    always_ff @(posedge clk) begin
        if (en_i) begin
            rdata_o <= mem_q[addr_i];
            if (we_i) mem_q[addr_i] <= wdata_i;
        end
    end

endmodule

// File: rtl/cpar_cache.sv
// Top: parallel-lookup set-associative line cache. Decodes the command,
// looks up tags and data in the same cycle, updates the use order and
// registers hit, miss, line data and evicted address for the next cycle.
// Assumes: NUM_LINES and WAYS are powers of two, WAYS <= NUM_LINES, and
// the set index fits in ADDR_W.
module cpar_cache #(
    parameter int NUM_LINES = 32,
    parameter int WAYS      = 32,
    parameter int ADDR_W    = 8,
    parameter int LINE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              rw_i,
    input  logic              inv_i,
    input  logic              repl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LINE_W-1:0] line_i,
    output logic [LINE_W-1:0] line_o,
    output logic              hit_o,
    output logic              miss_o,
    output logic [ADDR_W-1:0] old_addr_o
);

    import cpar_pkg::*;

    localparam int SETS   = NUM_LINES / WAYS;
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LIDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    cpar_op_e          op;
    logic [SET_W-1:0]  set_idx;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim_way, lru_way, sel_way;
    logic [ADDR_W-1:0] victim_tag;
    logic [LIDX_W-1:0] line_idx;
    logic              is_req, is_repl, is_drop, is_wr;

    assign op      = cpar_decode(req_i, rw_i, inv_i, repl_i);
    assign is_req  = (op != OP_IDLE) && (op != OP_REPLACE);
    assign is_repl = (op == OP_REPLACE);
    assign is_drop = (op == OP_READ_DROP) || (op == OP_WRITE_DROP);
    assign is_wr   = (op == OP_UPDATE) || (op == OP_WRITE_DROP);
    assign sel_way = is_repl ? victim_way : hit_way;

    // Set index from the low address bits, or zero when fully associative.
    generate
        if (SETS > 1) begin : g_sets
            assign set_idx  = addr_i[SET_W-1:0];
            assign line_idx = {set_idx, sel_way};
        end
        else begin : g_full
            assign set_idx  = '0;
            assign line_idx = LIDX_W'(sel_way);
        end
    endgenerate

    cpar_tag_unit #(
        .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_idx_i    (set_idx),
        .addr_i       (addr_i),
        .clr_en_i     (is_req && is_drop && hit),
        .fill_en_i    (is_repl),
        .wr_way_i     (sel_way),
        .lru_way_i    (lru_way),
        .hit_o        (hit),
        .hit_way_o    (hit_way),
        .victim_way_o (victim_way),
        .victim_tag_o (victim_tag)
    );

    cpar_lru #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx_i (set_idx),
        .promote_i (is_repl || (is_req && hit && !is_drop)),
        .demote_i  (is_req && hit && is_drop),
        .way_i     (sel_way),
        .lru_way_o (lru_way)
    );

    cpar_data_mem #(
        .DEPTH(NUM_LINES), .LINE_W(LINE_W), .AW(LIDX_W)
    ) u_data (
        .clk     (clk),
        .en_i    (is_repl || is_req),
        .we_i    (is_repl || (is_wr && hit)),
        .addr_i  (line_idx),
        .wdata_i (line_i),
        .rdata_o (line_o)
    );

    // Register lookup result flags; both drop when no request was made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o  <= 1'b0;
            miss_o <= 1'b0;
        end
        else begin
            hit_o  <= is_req && hit;
            miss_o <= is_req && !hit;
        end
    end

    // Capture the evicted line's address on a replace.
    always_ff @(posedge clk) begin
        if (!rst_n)       old_addr_o <= '0;
        else if (is_repl) old_addr_o <= victim_tag;
    end

endmodule

// File: rtl/cpar_cache_chk.sv
// Checker: temporal properties of the cache ports, bound into cpar_cache.
// Assumes: the caller never replaces an address that is already resident.
module cpar_cache_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              inv_i,
    input logic              repl_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              hit_o,
    input logic              miss_o
);

    // R2: a request is answered by exactly one flag.
    a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_i)) |-> (hit_o ^ miss_o));

    // R2: the flags are never high together.
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o));

    // R3: no request means both flags low.
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> (!hit_o && !miss_o));

    // R7: a replaced address hits on the very next request.
    a_r7_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(!req_i && repl_i, 2)
         && $past(req_i) && ($past(addr_i) == $past(addr_i, 2))) |-> hit_o);

    // R6: an invalidated address misses on the very next request.
    a_r6_drop_misses: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(req_i && inv_i, 2)
         && $past(req_i) && ($past(addr_i) == $past(addr_i, 2))) |-> miss_o);

endmodule

bind cpar_cache cpar_cache_chk #(.ADDR_W(ADDR_W)) u_cpar_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .inv_i  (inv_i),
    .repl_i (repl_i),
    .addr_i (addr_i),
    .hit_o  (hit_o),
    .miss_o (miss_o)
);

// File: tb/cpar_cache_bench.sv
// Bench: directed corner cases plus seeded random commands, compared with a
// behavioural model of sets, ways, ranks and data kept in this module.
module cpar_cache_bench;

    localparam int LINES = 16;
    localparam int WAYS  = 4;
    localparam int SETS  = LINES / WAYS;
    localparam int AW    = 8;
    localparam int LW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, rw = 1'b0, inv = 1'b0, rep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LW-1:0] din = '0;
    logic [LW-1:0] line_o;
    logic          hit_o, miss_o;
    logic [AW-1:0] old_addr_o;

    int n_chk = 0;
    int n_bad = 0;

    bit            m_valid [SETS][WAYS];
    logic [AW-1:0] m_tag   [SETS][WAYS];
    logic [LW-1:0] m_data  [SETS][WAYS];
    int            m_rank  [SETS][WAYS];

    always #10 clk = ~clk;

    cpar_cache #(.NUM_LINES(LINES), .WAYS(WAYS), .ADDR_W(AW), .LINE_W(LW)) u_cpar_cache (
        .clk(clk), .rst_n(rst_n), .req_i(req), .rw_i(rw), .inv_i(inv), .repl_i(rep),
        .addr_i(addr), .line_i(din), .line_o(line_o), .hit_o(hit_o),
        .miss_o(miss_o), .old_addr_o(old_addr_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int m_find(input int s, input logic [AW-1:0] a);
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == a) return w;
        return -1;
    endfunction

    task automatic m_promote(input int s, input int k);
        int r = m_rank[s][k];
        for (int w = 0; w < WAYS; w++) if (m_rank[s][w] < r) m_rank[s][w]++;
        m_rank[s][k] = 0;
    endtask

    task automatic m_demote(input int s, input int k);
        int r = m_rank[s][k];
        for (int w = 0; w < WAYS; w++) if (m_rank[s][w] > r) m_rank[s][w]--;
        m_rank[s][k] = WAYS - 1;
    endtask

    task automatic m_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0;
                m_rank[s][w]  = w;
            end
    endtask

    // Apply one command at a falling edge, update the model, compare results.
    task automatic do_op(input bit q, input bit wr, input bit iv, input bit rp,
                         input logic [AW-1:0] a, input logic [LW-1:0] d, input string tag);
        int s = int'(a) % SETS;
        int w = m_find(s, a);
        bit e_hit = 0, e_miss = 0, c_data = 0, c_old = 0;
        logic [LW-1:0] e_data = '0;
        logic [AW-1:0] e_old = '0;
        string t_flag, t_data;
        t_flag = (tag != "") ? tag : (q ? "R2" : "R3");
        t_data = (tag != "") ? tag : (!q ? "R7" : iv ? "R6" : wr ? "R5" : "R4");
        if (q) begin
            e_hit = (w >= 0); e_miss = (w < 0);
            if (w >= 0) begin
                c_data = 1; e_data = m_data[s][w];
                if (wr) m_data[s][w] = d;
                if (iv) begin m_valid[s][w] = 0; m_demote(s, w); end
                else m_promote(s, w);
            end
        end
        else if (rp) begin
            int v = -1;
            for (int k = WAYS - 1; k >= 0; k--) if (!m_valid[s][k]) v = k;
            if (v < 0) for (int k = 0; k < WAYS; k++) if (m_rank[s][k] == WAYS - 1) v = k;
            if (m_valid[s][v]) begin
                c_data = 1; c_old = 1; e_data = m_data[s][v]; e_old = m_tag[s][v];
            end
            m_valid[s][v] = 1; m_tag[s][v] = a; m_data[s][v] = d; m_promote(s, v);
        end
        req = q; rw = wr; inv = iv; rep = rp; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        req = 0; rw = 0; inv = 0; rep = 0;
        check(hit_o == e_hit, t_flag, "hit", int'(hit_o), int'(e_hit));
        check(miss_o == e_miss, t_flag, "miss", int'(miss_o), int'(e_miss));
        if (c_data) check(line_o == e_data, t_data, "line", int'(line_o), int'(e_data));
        if (c_old) check(old_addr_o == e_old, t_data, "old_addr", int'(old_addr_o), int'(e_old));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed = 32'h5eed_cafe;
        void'($urandom(seed));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: flags low after reset, then everything misses.
        check(!hit_o && !miss_o, "R10", "flags after reset", int'({hit_o, miss_o}), 0);
        do_op(1, 0, 0, 0, 8'd0, 8'h00, "R10");
        // R7: fill and read back; R4 read hit; R5 update read-first.
        do_op(0, 0, 0, 1, 8'd0, 8'hA0, "R7");
        do_op(1, 0, 0, 0, 8'd0, 8'h00, "R4");
        do_op(1, 1, 0, 0, 8'd0, 8'hB0, "R5");
        do_op(1, 0, 0, 0, 8'd0, 8'h00, "R5");
        // R3: idle and replace-only leave flags low.
        do_op(0, 0, 0, 0, 8'd0, 8'h00, "R3");
        do_op(0, 0, 0, 1, 8'd4, 8'hA4, "R3");
        do_op(0, 0, 0, 1, 8'd8, 8'hA8, "R7");
        do_op(0, 0, 0, 1, 8'd12, 8'hAC, "R7");
        // R9: a miss changes nothing; the full set still hits.
        do_op(1, 0, 0, 0, 8'd16, 8'h00, "R9");
        do_op(1, 0, 0, 0, 8'd4, 8'h00, "R9");
        // R8: touch 0 and 4; LRU is now address 8, evicted by replacing 16.
        do_op(1, 0, 0, 0, 8'd0, 8'h00, "R8");
        do_op(0, 0, 0, 1, 8'd16, 8'hC0, "R8");
        check(old_addr_o == 8'd8, "R8", "victim address", int'(old_addr_o), 8);
        // R11: set 1 fill leaves set 0 intact.
        do_op(0, 0, 0, 1, 8'd1, 8'hD1, "R11");
        do_op(1, 0, 0, 0, 8'd12, 8'h00, "R11");
        // R6: invalidate hit, then miss; invalidate on miss is harmless.
        do_op(1, 1, 1, 0, 8'd12, 8'hEE, "R6");
        do_op(1, 0, 0, 0, 8'd12, 8'h00, "R6");
        do_op(1, 0, 1, 0, 8'd40, 8'h00, "R6");
        // R1: request wins over replace is not used; pattern 0110 acts as idle.
        do_op(0, 1, 1, 0, 8'd0, 8'h00, "R1");
        do_op(1, 0, 0, 0, 8'd0, 8'h00, "R1");
        // R7: freed way is filled before the LRU way.
        do_op(0, 0, 0, 1, 8'd20, 8'hF4, "R7");
        do_op(1, 0, 0, 0, 8'd16, 8'h00, "R7");
        // Random mix over a small address pool.
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a = AW'($urandom_range(0, 23));
            logic [LW-1:0] d = LW'($urandom);
            int k = $urandom_range(0, 9);
            int s = int'(a) % SETS;
            if (k < 3) begin
                if (m_find(s, a) < 0) do_op(0, 0, 0, 1, a, d, "");
                else do_op(1, 0, 0, 0, a, d, "");
            end
            else if (k < 5) do_op(1, 0, 0, 0, a, d, "");
            else if (k < 7) do_op(1, 1, 0, 0, a, d, "");
            else if (k == 7) do_op(1, 0, 1, 0, a, d, "");
            else if (k == 8) do_op(1, 1, 1, 0, a, d, "");
            else do_op(0, 0, 0, 0, a, d, "");
        end
        finish_run();
    end

endmodule